// File: doc/BRIEF.md
# Two-Wire Slave with Banked Register Memory

This block is a two-wire serial slave in front of a 272-byte array held in flip-flops. The array is divided into a general-purpose area (000h–07Fh), a control window (080h–08Fh), a first lookup table (090h–0CFh) and a second lookup table (0D0h–10Fh). A master opens every transaction with a START condition and a slave address byte. The block acknowledges only when the device type and three strap pins match. A write carries one word-address byte followed by data bytes. A read either follows a write of the word address and a repeated START, or it reads from wherever the internal pointer was left.

SCL and SDA are brought into the system clock domain by synchronizers, and the block pulls SDA low through an open-drain enable. Two control bytes shape every access. A write-enable latch gates all writes except the write to the latch itself. A bank bit lets the single address byte reach the top sixteen locations. The block discards writes to a reserved window and clears reserved bits in the control bytes.

Top module: `tws_slave`

## Requirements
- R1: After reset SDA is released (sda_oe_o low) and all 272 bytes read as 00h, including both lookup tables.
- R2: The slave address byte is {1010b, three device bits, R/W} with R/W=1 meaning read. The block acknokwledges it by driving SDA low during the 9th clock only when the device bits equal dev_addr_i. On a mismatch it drives nothing until the next START.
- R3: Every byte is shifted most significant bit first, both the bytes it receives and the bytes it sends.
- R4: The write-enable latch is bit 0 of location 080h and is cleared by reset. Location 080h can always be written. A write to any other location is discarded while the latch is 0.
- R5: Writes to 088h–08Fh are discarded and those locations always read 00h.
- R6: Bits 7..1 of locations 080h and 081h are stored as 0 whatever is written, and read back as 0.
- R7: The bank bit is bit 0 of location 081h. While it is 1, word addresses 00h–0Fh select 100h–10Fh. Word addresses 10h–FFh are never affected by it.
- R8: Consecutive data bytes of one write go to consecutive addresses within the same 16-byte page, and wrap from the last byte of the page to its first.
- R9: A read advances one byte per transfer over the whole array, wrapping from 10Fh to 000h, for as long as the master acknowledges. After a NACK the block releases SDA and drives nothing until the next START.
- R10: A read that has no word address starts at the internal pointer. That pointer is one past the last byte read or written, taken within the page for writes.
- R11: The block acknowledges every byte of a write addressed to it: the address byte, the word-address byte and each data byte. It drives SDA only after a falling SCL edge and releases it at the end of each acknowledge clock.
- R12: STOP ends the transaction. Bytes clocked without a new START get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_addr_i | input | 3 | Device address strap pins |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when it makes START and STOP. Each SCL phase lasts longer than the synchronizer latency, so every edge shows up as a single event that is not merged with the next one. The stimulus holds SCL high and low for ten system clocks each and moves SDA a quarter period after the falling edge. It therefore never breaks the ordering that the start and stop detector relies on. The only case where no SDA edge follows a falling SCL is the stray byte after STOP, where SCL is lowered with SDA already high.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int          MEM_BYTES = 272;
  localparam int          AW        = 9;
  localparam logic [3:0]  DEV_TYPE  = 4'b1010;
  localparam logic [AW-1:0] CTL_WEL  = 9'h080;
  localparam logic [AW-1:0] CTL_BANK = 9'h081;
  localparam logic [AW-1:0] RSV_LO   = 9'h088;
  localparam logic [AW-1:0] RSV_HI   = 9'h08F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_RLOAD
  } tws_state_e;

  typedef enum logic [1:0] {K_ADDR, K_WORD, K_DATA} tws_kind_e;

  function automatic logic [7:0] wr_mask(logic [AW-1:0] a);
    return (a == CTL_WEL || a == CTL_BANK) ? 8'h01 : 8'hFF;
  endfunction

  function automatic logic is_rsv(logic [AW-1:0] a);
    return (a >= RSV_LO) && (a <= RSV_HI);
  endfunction

  function automatic logic [AW-1:0] map_word(logic [7:0] wa, logic bank);
    return {bank && (wa[7:4] == 4'h0), wa};
  endfunction
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/tws_proto.sv
module tws_proto
  import tws_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic [2:0]    dev_addr_i,
  input  logic          bank_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(MEM_BYTES - 1);

  tws_state_e state;
  tws_kind_e  kind;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       rd_mode;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      shreg     <= '0;
      bitcnt    <= '0;
      rd_mode   <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      ptr_o     <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state    <= ST_RX;
        kind     <= K_ADDR;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX:
            if (scl_rise_i && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall_i && bitcnt == 4'd8) begin
              bitcnt <= '0;
              unique case (kind)
                K_ADDR:
                  if (shreg[7:1] == {DEV_TYPE, dev_addr_i}) begin
                    rd_mode  <= shreg[0];
                    kind     <= K_WORD;
                    sda_oe_o <= 1'b1;
                    state    <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                K_WORD: begin
                  ptr_o    <= map_word(shreg, bank_i);
                  kind     <= K_DATA;
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_o;
                  wr_data_o <= shreg;
                  ptr_o     <= {ptr_o[AW-1:4], ptr_o[3:0] + 4'd1};
                  sda_oe_o  <= 1'b1;
                  state     <= ST_ACK;
                end
              endcase
            end
          ST_ACK:
            if (scl_fall_i) begin
              bitcnt <= '0;
              if (rd_mode) begin
                shreg    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                state    <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_RX;
              end
            end
          ST_TX:
            if (scl_rise_i) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall_i) begin
              if (bitcnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                ptr_o    <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
                state    <= ST_RACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_o <= ~shreg[6];
              end
            end
          ST_RACK:
            if (scl_rise_i) state <= sda_i ? ST_IDLE : ST_RLOAD;
          ST_RLOAD:
            if (scl_fall_i) begin
              shreg    <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              bitcnt   <= '0;
              state    <= ST_TX;
            end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/tws_bank_mem.sv
module tws_bank_mem
  import tws_pkg::*;
#(
  parameter int DEPTH = MEM_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          wel_o,
  output logic          bank_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0] mem [DEPTH];
  logic       allow;

  assign wel_o  = mem[CTL_WEL][0];
  assign bank_o = mem[CTL_BANK][0];
  assign allow  = wr_en_i && (wr_addr_i <= LAST) &&
                  ((wr_addr_i == CTL_WEL) || (wel_o && !is_rsv(wr_addr_i)));

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)
        mem[g] <= '0;
      else if (allow && wr_addr_i == AW'(g))
        mem[g] <= wr_data_i & wr_mask(AW'(g));
  end

  assign rd_data_o = (rd_addr_i <= LAST) ? mem[rd_addr_i] : 8'h00;
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_addr_i,
  output logic       sda_oe_o
);
  logic          sda_s, scl_rise, scl_fall, start, stop;
  logic          wr_en, wel, bank;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  tws_proto u_proto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .sda_i      (sda_s),
    .dev_addr_i (dev_addr_i),
    .bank_i     (bank),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .ptr_o      (rd_addr)
  );

  tws_bank_mem u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wel_o     (wel),
    .bank_o    (bank)
  );
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic       scl_fall,
  input logic       wr_en,
  input logic [8:0] wr_addr,
  input logic       wel,
  input logic       bank,
  input logic [8:0] rd_addr,
  input logic [7:0] rd_data
);
  a_r11_drive_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  a_r4_wel_own_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && wr_addr == 9'h080) |=> $stable(wel));

  a_r7_bank_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank) |-> $past(wr_en && wr_addr == 9'h081 && wel));

  a_r6_ctl_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr == 9'h080 || rd_addr == 9'h081) |-> rd_data[7:1] == 7'h00);

  a_r5_rsv_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr >= 9'h088 && rd_addr <= 9'h08F) |-> rd_data == 8'h00);

  a_r9_ptr_in_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr <= 9'h10F);
endmodule

bind tws_slave tws_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_o (sda_oe_o),
  .scl_fall (scl_fall),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wel      (wel),
  .bank     (bank),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data)
);

// File: tb/tws_slave_tb.sv
module tws_slave_tb;
  localparam int H = 10;
  localparam int Q = 5;
  localparam logic [7:0] A_WR = 8'hAA;  // 1010_101_0
  localparam logic [7:0] A_RD = 8'hAB;
  localparam logic [7:0] A_BAD = 8'hA8; // pins 100
  // {word address, data written, expected read}
  localparam logic [23:0] VEC [10] = '{
    24'h20_5A_5A, 24'h7F_C3_C3, 24'h82_A5_A5, 24'h87_3C_3C, 24'h8A_FF_00,
    24'h8F_11_00, 24'h90_96_96, 24'hCF_0F_0F, 24'hD0_E1_E1, 24'hFF_7E_7E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [2:0] dev = 3'b101;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  logic ack;

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  tws_slave u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .dev_addr_i (dev),
    .sda_oe_o   (sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); m_sda = 1'b0;
    tick(Q); m_scl = 1'b1;
    tick(H); m_sda = 1'b1;
    tick(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_sda = b[i];
      tick(Q); m_scl = 1'b1;
      tick(H); m_scl = 1'b0;
    end
    tick(Q); m_sda = 1'b1;
    tick(Q); m_scl = 1'b1;
    tick(Q); a = ~sda_line;
    tick(Q); m_scl = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_sda = 1'b1;
      tick(Q); m_scl = 1'b1;
      tick(Q); b[i] = sda_line;
      tick(Q); m_scl = 1'b0;
    end
    tick(Q); m_sda = ~give_ack;
    tick(Q); m_scl = 1'b1;
    tick(H); m_scl = 1'b0;
  endtask

  task automatic wr_xfer(input logic [7:0] wa, input int n);
    logic a;
    bus_start();
    put_byte(A_WR, a); chk("R11 addr ack", {7'd0, a}, 8'h01);
    put_byte(wa, a);   chk("R11 word ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], a); chk("R11 data ack", {7'd0, a}, 8'h01);
    end
    bus_stop();
  endtask

  task automatic rd_tail(input int n);
    logic a;
    logic [7:0] b;
    put_byte(A_RD, a); chk("R2 read ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < n; i++) begin
      get_byte(b, i != n - 1);
      rbuf[i] = b;
    end
    tick(Q);
    chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic rd_xfer(input logic [7:0] wa, input int n);
    logic a;
    bus_start();
    put_byte(A_WR, a); chk("R11 addr ack", {7'd0, a}, 8'h01);
    put_byte(wa, a);
    bus_start();
    rd_tail(n);
  endtask

  task automatic cur_rd(input int n);
    bus_start();
    rd_tail(n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R1 sda released", {7'd0, sda_oe}, 8'h00);
    rd_xfer(8'h95, 1); chk("R1 lut1 zero", rbuf[0], 8'h00);
    rd_xfer(8'hE0, 1); chk("R1 lut2 zero", rbuf[0], 8'h00);

    // R2 mismatch: no ack for address or following byte
    bus_start();
    put_byte(A_BAD, ack); chk("R2 mismatch no ack", {7'd0, ack}, 8'h00);
    put_byte(8'h10, ack); chk("R2 silent until start", {7'd0, ack}, 8'h00);
    bus_stop();

    // R4 write discarded with latch clear, latch itself writable
    wbuf[0] = 8'h55; wr_xfer(8'h10, 1);
    wbuf[0] = 8'h01; wr_xfer(8'h80, 1);
    rd_xfer(8'h80, 1); chk("R3 R4 latch set", rbuf[0], 8'h01);
    rd_xfer(8'h10, 1); chk("R4 discarded write", rbuf[0], 8'h00);

    // vector table
    for (int i = 0; i < 10; i++) begin
      wbuf[0] = VEC[i][15:8];
      wr_xfer(VEC[i][23:16], 1);
      rd_xfer(VEC[i][23:16], 1);
      if (VEC[i][23:16] >= 8'h88 && VEC[i][23:16] <= 8'h8F)
        chk("R5 reserved window", rbuf[0], VEC[i][7:0]);
      else
        chk("R3 region write/read", rbuf[0], VEC[i][7:0]);
    end

    // R6 reserved bits
    wbuf[0] = 8'hFF; wr_xfer(8'h80, 1);
    rd_xfer(8'h80, 1); chk("R6 wel upper bits", rbuf[0], 8'h01);

    // R8 page wrap
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    wr_xfer(8'h1E, 4);
    rd_xfer(8'h10, 2);
    chk("R8 wrapped byte 3", rbuf[0], 8'hC3);
    chk("R8 wrapped byte 4", rbuf[1], 8'hD4);
    rd_xfer(8'h1E, 2);
    chk("R8 page byte 1", rbuf[0], 8'hA1);
    chk("R8 page byte 2", rbuf[1], 8'hB2);

    // R10 current address read: pointer at 80h after reading 7Fh
    rd_xfer(8'h7F, 1); chk("R9 single read", rbuf[0], 8'hC3);
    cur_rd(1); chk("R10 current address", rbuf[0], 8'h01);

    // R7 bank, R9 wrap
    wbuf[0] = 8'h33; wr_xfer(8'h00, 1);
    wbuf[0] = 8'h5C; wr_xfer(8'h0F, 1);
    wbuf[0] = 8'h03; wr_xfer(8'h81, 1);
    rd_xfer(8'h81, 1); chk("R6 bank upper bits", rbuf[0], 8'h01);
    wbuf[0] = 8'h77; wr_xfer(8'h0F, 1);
    rd_xfer(8'h0F, 2);
    chk("R7 banked 10Fh", rbuf[0], 8'h77);
    chk("R9 wrap to 000h", rbuf[1], 8'h33);
    rd_xfer(8'h20, 1); chk("R7 high address unaffected", rbuf[0], 8'h5A);
    wbuf[0] = 8'h00; wr_xfer(8'h81, 1);
    rd_xfer(8'h0F, 1); chk("R7 bank cleared", rbuf[0], 8'h5C);

    // R12 byte without START after STOP
    m_scl = 1'b0;
    put_byte(A_WR, ack); chk("R12 no ack without start", {7'd0, ack}, 8'h00);
    bus_stop();

    // R4 latch is volatile, R1 array cleared
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(5);
    wbuf[0] = 8'h99; wr_xfer(8'h30, 1);
    rd_xfer(8'h30, 1); chk("R4 latch cleared by reset", rbuf[0], 8'h00);
    rd_xfer(8'h20, 1); chk("R1 array cleared", rbuf[0], 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule